// File: doc/BRIEF.md
# Segment-offset address generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. The address is the segment shifted left by four bits plus the offset, and the sum wraps within 20 bits. Each request has a kind: a data access, an instruction fetch, a stack access or a string step. For a data access, the segment comes from the pointer register that forms the address. The frame pointer implies the stack segment, and every other pointer implies the data segment. A valid segment override replaces that default.

Fetches always use the code segment with the instruction pointer, and stack accesses always use the stack segment with the stack pointer. A string step produces two addresses. The source is the data segment (or the override) with the source index. The destination is the extra segment with the destination index. The same step also returns both indices moved by one element. The element is one byte or one word, and the direction flag sets whether the indices count up or down. All results are registered and appear in the cycle after the request.

Top module: `agen_core`

## Requirements
- R1: While reset is low and after it, until the first request, `addr_valid` and `idx_valid` are 0 and `addr`, `dst_addr`, `src_idx_next` and `dst_idx_next` are 0.
- R2: A request sampled on a clock edge gives `addr_valid`=1 after that edge, with `addr` = (segment * 16 + offset) mod 2^20.
- R3: A data request (`req_kind`=0) with no override and `ptr_sel` = 0 (base), 2 (source index) or 3 (destination index) uses `seg_data` with `offset`.
- R4: A data request with no override and `ptr_sel`=1 (frame pointer) uses `seg_stack` with `offset`.
- R5: With `ovr_valid`=1, data and string-source requests use the segment named by `ovr_seg`: 0 extra, 1 code, 2 stack, 3 data.
- R6: A fetch request (`req_kind`=1) uses `seg_code` with `ip`, whatever `ptr_sel`, `offset` and the override hold.
- R7: A stack request (`req_kind`=2) uses `seg_stack` with `sp`, whatever `ptr_sel`, `offset` and the override hold.
- R8: A string request (`req_kind`=3) gives `addr` from the source segment (the data segment or the override) with `src_idx`, and `dst_addr` from `seg_extra` with `dst_idx`. The override never changes `dst_addr`.
- R9: A string request sets `idx_valid`=1 and moves both indices by 1 (`elem_word`=0) or 2 (`elem_word`=1). They go up when `dir_down`=0 and down when it is 1, and wrap modulo 2^16.
- R10: A cycle with no request gives `addr_valid`=0 and leaves `addr` unchanged. A non-string request gives `idx_valid`=0 and leaves `dst_addr`, `src_idx_next` and `dst_idx_next` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 data, 1 fetch, 2 stack, 3 string step |
| ptr_sel | input | 2 | Pointer forming a data address: 0 base, 1 frame, 2 source index, 3 destination index |
| offset | input | 16 | Offset for data requests |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| seg_extra | input | 16 | Extra segment value |
| seg_code | input | 16 | Code segment value |
| seg_stack | input | 16 | Stack segment value |
| seg_data | input | 16 | Data segment value |
| ip | input | 16 | Instruction pointer |
| sp | input | 16 | Stack pointer |
| src_idx | input | 16 | Current source index |
| dst_idx | input | 16 | Current destination index |
| dir_down | input | 1 | Direction flag, 1 means the indices decrement |
| elem_word | input | 1 | String element size, 1 means word |
| addr_valid | output | 1 | `addr` holds a new result |
| addr | output | 20 | Physical address (the source address for a string step) |
| idx_valid | output | 1 | String-step results are new |
| dst_addr | output | 20 | String destination physical address |
| src_idx_next | output | 16 | Stepped source index |
| dst_idx_next | output | 16 | Stepped destination index |

## Verification
Each result sits in an output register for one cycle only, so a wrong segment choice or a wrong step appears at the ports on the edge right after the request. A bad segment pick usually moves `addr` by a multiple of 16, while a stepper fault shows up in the low bits of the indices or at the wrap at 0 and 0xFFFF. A register that fails to hold shows up on the first idle cycle after a request. The bench therefore compares every output on every cycle, under random traffic and under directed corners.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    REQ_DATA   = 2'd0,
    REQ_FETCH  = 2'd1,
    REQ_STACK  = 2'd2,
    REQ_STRING = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    PTR_BASE  = 2'd0,
    PTR_FRAME = 2'd1,
    PTR_SRC   = 2'd2,
    PTR_DST   = 2'd3
  } ptr_sel_e;

  localparam int NUM_SEGS = 4;
endpackage

// File: rtl/agen_seg_pick.sv
module agen_seg_pick
  import agen_pkg::*;
(
  input  ptr_sel_e   ptr,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_seg,
  output seg_id_e    pick,
  output logic [NUM_SEGS-1:0] pick_hot
);
  always_comb begin
    if (ovr_valid)            pick = seg_id_e'(ovr_seg);
    else if (ptr == PTR_FRAME) pick = SEG_STACK;
    else                      pick = SEG_DATA;
    pick_hot = NUM_SEGS'(1) << pick;
  end
endmodule

// File: rtl/agen_phys_add.sv
module agen_phys_add #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  function automatic logic [ADDR_W-1:0] phys_of(input logic [SEG_W-1:0] s,
                                               input logic [OFF_W-1:0] o);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] disp;
    base = ADDR_W'(s) << SEG_SHIFT;
    disp = ADDR_W'(o);
    return base + disp;
  endfunction

  assign phys = phys_of(seg, off);
endmodule

// File: rtl/agen_index_step.sv
module agen_index_step #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] cur,
  input  logic             dir_down,
  input  logic             elem_word,
  output logic [IDX_W-1:0] nxt
);
  function automatic logic [IDX_W-1:0] stepped(input logic [IDX_W-1:0] v,
                                               input logic down,
                                               input logic word);
    logic [IDX_W-1:0] amt;
    amt = word ? IDX_W'(2) : IDX_W'(1);
    return down ? (v - amt) : (v + amt);
  endfunction

  assign nxt = stepped(cur, dir_down, elem_word);
endmodule

// File: rtl/agen_core.sv
module agen_core
  import agen_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [1:0]                   req_kind,
  input  logic [1:0]                   ptr_sel,
  input  logic [OFF_W-1:0]             offset,
  input  logic                         ovr_valid,
  input  logic [1:0]                   ovr_seg,
  input  logic [SEG_W-1:0]             seg_extra,
  input  logic [SEG_W-1:0]             seg_code,
  input  logic [SEG_W-1:0]             seg_stack,
  input  logic [SEG_W-1:0]             seg_data,
  input  logic [OFF_W-1:0]             ip,
  input  logic [OFF_W-1:0]             sp,
  input  logic [OFF_W-1:0]             src_idx,
  input  logic [OFF_W-1:0]             dst_idx,
  input  logic                         dir_down,
  input  logic                         elem_word,
  output logic                         addr_valid,
  output logic [SEG_W+SEG_SHIFT-1:0]   addr,
  output logic                         idx_valid,
  output logic [SEG_W+SEG_SHIFT-1:0]   dst_addr,
  output logic [OFF_W-1:0]             src_idx_next,
  output logic [OFF_W-1:0]             dst_idx_next
);
  localparam int ADDR_W  = SEG_W + SEG_SHIFT;
  localparam int NUM_PTR = 2;

  req_kind_e kind;
  ptr_sel_e  eff_ptr;
  seg_id_e   pick;
  logic [NUM_SEGS-1:0] pick_hot;
  logic [SEG_W-1:0]    seg_bank   [NUM_SEGS];
  logic [SEG_W-1:0]    seg_masked [NUM_SEGS];
  logic [SEG_W-1:0]    picked_seg;
  logic [SEG_W-1:0]    prim_seg;
  logic [OFF_W-1:0]    prim_off;
  logic [ADDR_W-1:0]   prim_phys;
  logic [ADDR_W-1:0]   dst_phys;
  logic [OFF_W-1:0]    idx_cur  [NUM_PTR];
  logic [OFF_W-1:0]    idx_nxt  [NUM_PTR];
  logic                string_req;

  assign kind       = req_kind_e'(req_kind);
  assign string_req = req_valid && (kind == REQ_STRING);
  assign eff_ptr    = (kind == REQ_STRING) ? PTR_SRC : ptr_sel_e'(ptr_sel);

  assign seg_bank[SEG_EXTRA] = seg_extra;
  assign seg_bank[SEG_CODE]  = seg_code;
  assign seg_bank[SEG_STACK] = seg_stack;
  assign seg_bank[SEG_DATA]  = seg_data;

  agen_seg_pick u_pick (
    .ptr       (eff_ptr),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .pick      (pick),
    .pick_hot  (pick_hot)
  );

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_segmask
    assign seg_masked[g] = pick_hot[g] ? seg_bank[g] : '0;
  end

  always_comb begin
    picked_seg = '0;
    for (int i = 0; i < NUM_SEGS; i++) picked_seg = picked_seg | seg_masked[i];
  end

  always_comb begin
    unique case (kind)
      REQ_FETCH:  begin prim_seg = seg_code;   prim_off = ip;      end
      REQ_STACK:  begin prim_seg = seg_stack;  prim_off = sp;      end
      REQ_STRING: begin prim_seg = picked_seg; prim_off = src_idx; end
      default:    begin prim_seg = picked_seg; prim_off = offset;  end
    endcase
  end

  agen_phys_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_prim_add (
    .seg  (prim_seg),
    .off  (prim_off),
    .phys (prim_phys)
  );

  agen_phys_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_dst_add (
    .seg  (seg_extra),
    .off  (dst_idx),
    .phys (dst_phys)
  );

  assign idx_cur[0] = src_idx;
  assign idx_cur[1] = dst_idx;

  for (genvar p = 0; p < NUM_PTR; p++) begin : g_step
    agen_index_step #(.IDX_W(OFF_W)) u_step (
      .cur       (idx_cur[p]),
      .dir_down  (dir_down),
      .elem_word (elem_word),
      .nxt       (idx_nxt[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid   <= 1'b0;
      addr         <= '0;
      idx_valid    <= 1'b0;
      dst_addr     <= '0;
      src_idx_next <= '0;
      dst_idx_next <= '0;
    end else begin
      addr_valid <= req_valid;
      idx_valid  <= string_req;
      if (req_valid) addr <= prim_phys;
      if (string_req) begin
        dst_addr     <= dst_phys;
        src_idx_next <= idx_nxt[0];
        dst_idx_next <= idx_nxt[1];
      end
    end
  end

  // Low address bits come straight from the offset chosen in the request cycle
  assert_low_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> addr[SEG_SHIFT-1:0] == $past(prim_off[SEG_SHIFT-1:0]));

  assert_default_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == REQ_DATA && !ovr_valid && ptr_sel != PTR_FRAME) |-> pick == SEG_DATA);

  assert_frame_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == REQ_DATA && !ovr_valid && ptr_sel == PTR_FRAME) |-> pick == SEG_STACK);

  assert_override_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ovr_valid && (kind == REQ_DATA || kind == REQ_STRING)) |-> pick == seg_id_e'(ovr_seg));

  assert_dst_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> dst_addr[SEG_SHIFT-1:0] == $past(dst_idx[SEG_SHIFT-1:0]));

  // Both indices move by the same amount, so their distance is kept
  assert_gap_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> OFF_W'(src_idx_next - dst_idx_next) == $past(OFF_W'(src_idx - dst_idx)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && !idx_valid && $stable(addr)));
endmodule

// File: tb/test_agen_core.sv
module test_agen_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0, ptr_sel = '0, ovr_seg = '0;
  logic [15:0] offset = '0, seg_extra = '0, seg_code = '0, seg_stack = '0, seg_data = '0;
  logic [15:0] ip = '0, sp = '0, src_idx = '0, dst_idx = '0;
  logic        ovr_valid = 1'b0, dir_down = 1'b0, elem_word = 1'b0;
  logic        addr_valid, idx_valid;
  logic [19:0] addr, dst_addr;
  logic [15:0] src_idx_next, dst_idx_next;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  logic        e_av = 0, e_iv = 0;
  logic [19:0] e_addr = 0, e_dst = 0;
  logic [15:0] e_sn = 0, e_dn = 0;

  always #4 clk = ~clk;

  agen_core i_agen_core (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .ptr_sel(ptr_sel),
    .offset(offset), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .seg_extra(seg_extra),
    .seg_code(seg_code), .seg_stack(seg_stack), .seg_data(seg_data), .ip(ip), .sp(sp),
    .src_idx(src_idx), .dst_idx(dst_idx), .dir_down(dir_down), .elem_word(elem_word),
    .addr_valid(addr_valid), .addr(addr), .idx_valid(idx_valid), .dst_addr(dst_addr),
    .src_idx_next(src_idx_next), .dst_idx_next(dst_idx_next)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint seg_of(input logic [1:0] code);
    case (code)
      2'd0: return seg_extra;
      2'd1: return seg_code;
      2'd2: return seg_stack;
      default: return seg_data;
    endcase
  endfunction

  function automatic logic [19:0] lin(input longint s, input longint o);
    return 20'((s * 16 + o) % 1048576);
  endfunction

  function automatic logic [15:0] mv(input longint v, input logic down, input logic word);
    longint d;
    d = word ? 2 : 1;
    return 16'((v + 65536 + (down ? -d : d)) % 65536);
  endfunction

  task automatic compare_all(input string tag);
    check(tag, "addr_valid", addr_valid, e_av);
    check(tag, "addr", addr, e_addr);
    check(tag, "idx_valid", idx_valid, e_iv);
    check(tag, "dst_addr", dst_addr, e_dst);
    check(tag, "src_idx_next", src_idx_next, e_sn);
    check(tag, "dst_idx_next", dst_idx_next, e_dn);
  endtask

  // drive one cycle (called just after a falling edge), then compare after the next rising edge
  task automatic apply(input logic rv, input logic [1:0] kind, input logic [1:0] ptr,
                       input logic ov, input logic [1:0] oseg, input logic dn, input logic w);
    string tag;
    longint s;
    req_valid = rv; req_kind = kind; ptr_sel = ptr; ovr_valid = ov; ovr_seg = oseg;
    dir_down = dn; elem_word = w;
    tag = "R10";
    if (rv) begin
      e_av = 1;
      case (kind)
        2'd1: begin tag = "R6"; e_addr = lin(seg_code, ip); end
        2'd2: begin tag = "R7"; e_addr = lin(seg_stack, sp); end
        2'd3: begin
          tag = "R8/R9";
          s = ov ? seg_of(oseg) : seg_data;
          e_addr = lin(s, src_idx);
          e_dst = lin(seg_extra, dst_idx);
          e_sn = mv(src_idx, dn, w);
          e_dn = mv(dst_idx, dn, w);
        end
        default: begin
          if (ov) begin tag = "R5"; s = seg_of(oseg); end
          else if (ptr == 2'd1) begin tag = "R4"; s = seg_stack; end
          else begin tag = "R3"; s = seg_data; end
          e_addr = lin(s, offset);
        end
      endcase
      e_iv = (kind == 2'd3);
    end else begin
      e_av = 0; e_iv = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic scramble();
    seg_extra = 16'($urandom); seg_code = 16'($urandom); seg_stack = 16'($urandom);
    seg_data = 16'($urandom); ip = 16'($urandom); sp = 16'($urandom);
    src_idx = 16'($urandom); dst_idx = 16'($urandom); offset = 16'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    scramble();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");              // during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");              // after reset, no request yet

    // R2 wrap corner: top segment plus top offset
    seg_data = 16'hFFFF; offset = 16'hFFFF;
    apply(1, 2'd0, 2'd0, 0, 2'd0, 0, 0);
    check("R2", "wrap addr", addr, 20'h0FFEF);

    // R3 default data for base, source and destination pointers
    scramble();
    apply(1, 2'd0, 2'd0, 0, 2'd0, 0, 0);
    apply(1, 2'd0, 2'd2, 0, 2'd0, 0, 0);
    apply(1, 2'd0, 2'd3, 0, 2'd0, 0, 0);
    // R4 frame pointer picks the stack segment
    apply(1, 2'd0, 2'd1, 0, 2'd0, 0, 0);
    // R5 every override code, including over the frame pointer
    for (int c = 0; c < 4; c++) apply(1, 2'd0, 2'd1, 1, 2'(c), 0, 0);
    // R6 fetch ignores override and pointer
    apply(1, 2'd1, 2'd1, 1, 2'd0, 0, 0);
    // R7 stack ignores override
    apply(1, 2'd2, 2'd0, 1, 2'd3, 0, 0);
    // R10 idle holds the string results across a non-string request and an idle cycle
    apply(1, 2'd3, 2'd0, 0, 2'd0, 0, 1);
    apply(1, 2'd0, 2'd0, 0, 2'd0, 0, 0);
    apply(0, 2'd0, 2'd0, 0, 2'd0, 0, 0);

    // R9 wrap corners
    src_idx = 16'hFFFF; dst_idx = 16'h0000;
    apply(1, 2'd3, 2'd0, 0, 2'd0, 0, 0);
    check("R9", "src up wrap", src_idx_next, 16'h0000);
    check("R9", "dst up", dst_idx_next, 16'h0001);
    src_idx = 16'h0001; dst_idx = 16'h0000;
    apply(1, 2'd3, 2'd0, 0, 2'd0, 1, 1);
    check("R9", "src down word wrap", src_idx_next, 16'hFFFF);
    check("R9", "dst down word wrap", dst_idx_next, 16'hFFFE);
    // R8 override moves the source but never the destination
    scramble();
    apply(1, 2'd3, 2'd0, 1, 2'd1, 0, 1);
    check("R8", "dst uses extra", dst_addr, lin(seg_extra, dst_idx));

    // random traffic compared every cycle
    for (int n = 0; n < 2000; n++) begin
      if (n % 7 == 0) scramble();
      apply(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 1'($urandom),
            2'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule